// File: doc/BRIEF.md
# Bus Mode Initialization Controller

This block sits in a host bridge on the secondary side of a PCI/PCI-X bus and chooses the bus mode and clock frequency while the bus is held in reset. It waits a set number of clocks for the board straps to settle. It then latches three inputs: the 66 MHz capability pin, the three-level PCI-X capability pin (already digitised into a 2-bit level code) and a board strap that permits 133 MHz operation. It decodes these into one mode and frequency code.

Once the choice is latched, the controller drives a pattern on DEVSEL#, STOP# and TRDY#. This pattern tells every device on the bus which mode to enter. FRAME# and IRDY# stay deasserted while the pattern is driven. The two bus reset outputs stay asserted until the bridge drops its reset request. They then rise together while the pattern is still on the lines. The pattern is held for a set number of clocks after that. The controller then releases all five lines and reports the mode as valid. A new reset request, or the controller's own reset, starts the sequence again and re-samples the straps.

Top module: `busmode_init_ctrl`

## Requirements
- R1: With capability level code 2'b00 (grounded), the block selects conventional PCI (`pcix_mode_o`=0). The frequency code (`freq_code_o`) is 0 (33 MHz) when `m66_open_i`=0 and 1 (66 MHz) when `m66_open_i`=1, whatever `allow133_i` is.
- R2: With capability level code 2'b01 (mid level), the block selects PCI-X at 66 MHz (`pcix_mode_o`=1, code 2) for either value of `m66_open_i`.
- R3: With capability level code 2'b10 (open), the block selects PCI-X. The code is 3 (100 MHz) when `m66_open_i`=0. It is 4 (133 MHz) when `m66_open_i`=1 and `allow133_i`=1. It is 3 when `m66_open_i`=1 and `allow133_i`=0.
- R4: Level code 2'b11 is reserved. It yields conventional PCI with code 0 and sets `strap_err_o`=1. Every other level code leaves `strap_err_o`=0.
- R5: After a reset starts, the straps are latched exactly SETTLE_CYCLES clocks later. Until then `ctl_oe_o`=0, `freq_code_o`=0, `pcix_mode_o`=0, `mode_valid_o`=0 and both bus reset outputs are 0.
- R6: While `ctl_oe_o`=1, `devsel_n_o` stays 1. `stop_n_o` is 0 only for codes 3 and 4. `trdy_n_o` is 0 only for codes 2 and 4. Conventional modes drive all three lines high.
- R7: While `ctl_oe_o`=1, `frame_n_o` and `irdy_n_o` are 1.
- R8: After the latch, both bits of `bus_rst_n_o` stay 0 for as long as `bus_rst_req_i` is 1. One clock after the request drops, both bits rise together, and the pattern is unchanged and still driven.
- R9: The pattern stays driven for HOLD_CYCLES clocks after the bus resets rise. The block then sets `ctl_oe_o`=0 and `mode_valid_o`=1.
- R10: Strap changes after the latch have no effect on the mode, the code or the pattern until the next reset.
- R11: Raising `bus_rst_req_i` after the sequence has finished restarts it on the next clock. `mode_valid_o` drops, the bus resets are asserted and the straps are sampled again.
- R12: A synchronous low `rst_n` puts the block in the settling phase with bus resets asserted, lines released, `mode_valid_o`=0 and the code cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low controller reset |
| bus_rst_req_i | input | 1 | Bridge request to hold the secondary bus in reset |
| m66_open_i | input | 1 | 66 MHz capability pin, 1 = open, 0 = grounded |
| cap_lvl_i | input | 2 | PCI-X capability level: 00 ground, 01 mid, 10 open, 11 reserved |
| allow133_i | input | 1 | Board strap permitting 133 MHz |
| bus_rst_n_o | output | NUM_BUS | Active-low secondary bus reset outputs |
| ctl_oe_o | output | 1 | Output enable for the five bus control lines |
| frame_n_o | output | 1 | FRAME# drive value |
| irdy_n_o | output | 1 | IRDY# drive value |
| devsel_n_o | output | 1 | DEVSEL# drive value |
| stop_n_o | output | 1 | STOP# drive value |
| trdy_n_o | output | 1 | TRDY# drive value |
| pcix_mode_o | output | 1 | 1 when the latched mode is PCI-X |
| freq_code_o | output | 3 | 0 = 33, 1 = 66, 2 = PCI-X 66, 3 = PCI-X 100, 4 = PCI-X 133 |
| mode_valid_o | output | 1 | Sequence finished and mode latched |
| strap_err_o | output | 1 | Reserved capability level was sampled |

## Verification
A wrong latched configuration shows up in the same clock that the lines are enabled. It appears both on the frequency code and on the STOP#/TRDY# pattern, so a decode fault is visible SETTLE_CYCLES clocks after reset starts. An off-by-one in the shared counter moves the rise of `ctl_oe_o` or its fall before `mode_valid_o` by one clock, so every check is taken on an exact cycle. A sequencer that re-latches or misses the request shows up as a changed code at the end of the sequence, or as bus resets that rise while the request is still held.

// File: rtl/busmode_pkg.sv
// Shared types for the bus mode initialization controller.
// Assumes: capability level already digitised to a 2-bit code.
package busmode_pkg;

    typedef enum logic [1:0] {
        CAP_GND  = 2'b00,
        CAP_MID  = 2'b01,
        CAP_OPEN = 2'b10,
        CAP_RSVD = 2'b11
    } cap_lvl_e;

    typedef enum logic [2:0] {
        FREQ_C33  = 3'd0,
        FREQ_C66  = 3'd1,
        FREQ_X66  = 3'd2,
        FREQ_X100 = 3'd3,
        FREQ_X133 = 3'd4
    } freq_e;

    typedef enum logic [1:0] {
        ST_SETTLE = 2'd0,
        ST_DRIVE  = 2'd1,
        ST_HOLD   = 2'd2,
        ST_DONE   = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic  pcix;
        freq_e freq;
        logic  err;
    } bus_cfg_t;

    localparam bus_cfg_t CFG_CLEAR = '{pcix: 1'b0, freq: FREQ_C33, err: 1'b0};

endpackage

// File: rtl/strap_decoder.sv
// Combinational decode of the board straps into a bus configuration.
// Assumes: inputs may change at any time; the sequencer decides when to latch.
module strap_decoder
    import busmode_pkg::*;
(
    input  logic       m66_open,
    input  logic [1:0] cap_lvl,
    input  logic       allow133,
    output bus_cfg_t   cfg
);

    // Map the capability level and 66 MHz pin to a mode and frequency.
    always_comb begin
        cfg = CFG_CLEAR;
        case (cap_lvl)
            CAP_GND:  cfg.freq = m66_open ? FREQ_C66 : FREQ_C33;
            CAP_MID: begin
                cfg.pcix = 1'b1;
                cfg.freq = FREQ_X66;
            end
            CAP_OPEN: begin
                cfg.pcix = 1'b1;
                cfg.freq = (m66_open && allow133) ? FREQ_X133 : FREQ_X100;
            end
            default:  cfg.err = 1'b1;
        endcase
    end

endmodule

// File: rtl/init_sequencer.sv
// Phase sequencer: settle, drive under reset, hold after release, done.
// Assumes: SETTLE_CYCLES >= 1 and HOLD_CYCLES >= 1; one counter serves both windows.
module init_sequencer
    import busmode_pkg::*;
#(
    parameter int SETTLE_CYCLES = 8,
    parameter int HOLD_CYCLES   = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_rst_req,
    input  bus_cfg_t   cfg_in,
    output bus_cfg_t   cfg_q,
    output seq_state_e state
);

    localparam int CNT_MAX = (SETTLE_CYCLES > HOLD_CYCLES) ? SETTLE_CYCLES : HOLD_CYCLES;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYCLES - 1);
    localparam logic [CNT_W-1:0] HOLD_LAST   = CNT_W'(HOLD_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    // Advance phases, count windows, latch the decoded straps once per reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_SETTLE;
            cnt   <= '0;
            cfg_q <= CFG_CLEAR;
        end else begin
            case (state)
                ST_SETTLE: begin
                    if (cnt == SETTLE_LAST) begin
                        state <= ST_DRIVE;
                        cnt   <= '0;
                        cfg_q <= cfg_in;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_DRIVE: begin
                    if (!bus_rst_req) begin
                        state <= ST_HOLD;
                        cnt   <= '0;
                    end
                end
                ST_HOLD: begin
                    if (bus_rst_req) begin
                        state <= ST_SETTLE;
                        cnt   <= '0;
                        cfg_q <= CFG_CLEAR;
                    end else if (cnt == HOLD_LAST) begin
                        state <= ST_DONE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    if (bus_rst_req) begin
                        state <= ST_SETTLE;
                        cnt   <= '0;
                        cfg_q <= CFG_CLEAR;
                    end
                end
            endcase
        end
    end

    AST_LATCH_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_SETTLE && $past(state) != ST_SETTLE) |-> $stable(cfg_q)) // R10
        else $error("latched configuration changed outside settling");

endmodule

// File: rtl/pattern_driver.sv
// Turns the phase and latched configuration into pin values and enables.
// Assumes: the pad ring tri-states the five control lines when the enable is low.
module pattern_driver
    import busmode_pkg::*;
#(
    parameter int NUM_BUS = 2
) (
    input  seq_state_e   state,
    input  bus_cfg_t     cfg_q,
    output logic [NUM_BUS-1:0] bus_rst_n,
    output logic         ctl_oe,
    output logic         frame_n,
    output logic         irdy_n,
    output logic         devsel_n,
    output logic         stop_n,
    output logic         trdy_n,
    output logic         mode_valid
);

    logic [2:0] pat;  // {devsel_n, stop_n, trdy_n}
    logic       rel;

    // Choose the signalling pattern for the latched frequency.
    always_comb begin
        case (cfg_q.freq)
            FREQ_X66:  pat = 3'b110;
            FREQ_X100: pat = 3'b101;
            FREQ_X133: pat = 3'b100;
            default:   pat = 3'b111;
        endcase
    end

    // Derive phase-dependent enables and reset levels.
    always_comb begin
        rel        = (state == ST_HOLD) || (state == ST_DONE);
        ctl_oe     = (state == ST_DRIVE) || (state == ST_HOLD);
        mode_valid = (state == ST_DONE);
        frame_n    = 1'b1;
        irdy_n     = 1'b1;
        devsel_n   = ctl_oe ? pat[2] : 1'b1;
        stop_n     = ctl_oe ? pat[1] : 1'b1;
        trdy_n     = ctl_oe ? pat[0] : 1'b1;
    end

    // Fan the single release level out to every bus reset output.
    for (genvar g = 0; g < NUM_BUS; g++) begin : g_rst
        assign bus_rst_n[g] = rel;
    end

endmodule

// File: rtl/busmode_init_ctrl.sv
// Top: samples straps under reset, signals the chosen mode on the bus
// control lines across reset release, then reports the mode.
// Assumes: clk runs throughout reset; rst_n is synchronous.
module busmode_init_ctrl
    import busmode_pkg::*;
#(
    parameter int SETTLE_CYCLES = 8,
    parameter int HOLD_CYCLES   = 4,
    parameter int NUM_BUS       = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_rst_req_i,
    input  logic               m66_open_i,
    input  logic [1:0]         cap_lvl_i,
    input  logic               allow133_i,
    output logic [NUM_BUS-1:0] bus_rst_n_o,
    output logic               ctl_oe_o,
    output logic               frame_n_o,
    output logic               irdy_n_o,
    output logic               devsel_n_o,
    output logic               stop_n_o,
    output logic               trdy_n_o,
    output logic               pcix_mode_o,
    output logic [2:0]         freq_code_o,
    output logic               mode_valid_o,
    output logic               strap_err_o
);

    bus_cfg_t   cfg_dec;
    bus_cfg_t   cfg_q;
    seq_state_e state;

    strap_decoder u_dec (
        .m66_open (m66_open_i),
        .cap_lvl  (cap_lvl_i),
        .allow133 (allow133_i),
        .cfg      (cfg_dec)
    );

    init_sequencer #(
        .SETTLE_CYCLES (SETTLE_CYCLES),
        .HOLD_CYCLES   (HOLD_CYCLES)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_rst_req (bus_rst_req_i),
        .cfg_in      (cfg_dec),
        .cfg_q       (cfg_q),
        .state       (state)
    );

    pattern_driver #(
        .NUM_BUS (NUM_BUS)
    ) u_drv (
        .state      (state),
        .cfg_q      (cfg_q),
        .bus_rst_n  (bus_rst_n_o),
        .ctl_oe     (ctl_oe_o),
        .frame_n    (frame_n_o),
        .irdy_n     (irdy_n_o),
        .devsel_n   (devsel_n_o),
        .stop_n     (stop_n_o),
        .trdy_n     (trdy_n_o),
        .mode_valid (mode_valid_o)
    );

    assign pcix_mode_o = cfg_q.pcix;
    assign freq_code_o = cfg_q.freq;
    assign strap_err_o = cfg_q.err;

    AST_NO_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_oe_o |-> devsel_n_o) // R6
        else $error("reserved pattern driven");

    AST_FRAME_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_oe_o |-> (frame_n_o && irdy_n_o)) // R7
        else $error("FRAME#/IRDY# asserted during pattern");

    AST_PATTERN_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_rst_n_o[0]) |-> (ctl_oe_o && $stable({stop_n_o, trdy_n_o}))) // R8
        else $error("pattern not stable across reset release");

    AST_VALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        mode_valid_o |-> (!ctl_oe_o && (&bus_rst_n_o))) // R9
        else $error("mode valid while lines driven or bus in reset");

endmodule

// File: tb/busmode_init_ctrl_tb.sv
module busmode_init_ctrl_tb;

    localparam int S  = 8;
    localparam int H  = 4;
    localparam int NB = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b1;
    logic          m66 = 1'b0;
    logic [1:0]    cap = 2'b00;
    logic          a133 = 1'b1;
    logic [NB-1:0] brst_n;
    logic          oe, frame_n, irdy_n, devsel_n, stop_n, trdy_n;
    logic          pcix, valid, err;
    logic [2:0]    freq;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    busmode_init_ctrl #(
        .SETTLE_CYCLES (S),
        .HOLD_CYCLES   (H),
        .NUM_BUS       (NB)
    ) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_rst_req_i (req),
        .m66_open_i    (m66),
        .cap_lvl_i     (cap),
        .allow133_i    (a133),
        .bus_rst_n_o   (brst_n),
        .ctl_oe_o      (oe),
        .frame_n_o     (frame_n),
        .irdy_n_o      (irdy_n),
        .devsel_n_o    (devsel_n),
        .stop_n_o      (stop_n),
        .trdy_n_o      (trdy_n),
        .pcix_mode_o   (pcix),
        .freq_code_o   (freq),
        .mode_valid_o  (valid),
        .strap_err_o   (err)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // Body of one sequence, entered at the negedge after the clock that began settling.
    task automatic run_body(input int ef, input int ep, input int ee,
                            input int extra, input bit disturb);
        int es = (ef == 3 || ef == 4) ? 0 : 1;
        int et = (ef == 2 || ef == 4) ? 0 : 1;
        repeat (S - 1) @(posedge clk);
        @(negedge clk);
        check("R5 oe low while settling", oe, 0);
        check("R5 code clear while settling", freq, 0);
        check("R5 bus reset held", brst_n, 0);
        @(posedge clk);
        @(negedge clk);
        check("R5 oe at latch", oe, 1);
        check("R1 R2 R3 freq code", freq, ef);
        check("R1 R2 R3 pcix mode", pcix, ep);
        check("R4 strap_err", err, ee);
        check("R6 devsel_n", devsel_n, 1);
        check("R6 stop_n", stop_n, es);
        check("R6 trdy_n", trdy_n, et);
        check("R7 frame_n irdy_n", {frame_n, irdy_n}, 3);
        if (disturb) begin
            m66 = 1'b0;
            cap = 2'b00;
            a133 = 1'b0;
        end
        for (int i = 0; i < extra; i++) begin
            @(posedge clk);
            @(negedge clk);
            check("R8 reset held while requested", brst_n, 0);
            check("R8 pattern driven while requested", oe, 1);
        end
        req = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R8 both resets rise together", brst_n, 3);
        check("R8 pattern still driven", oe, 1);
        check("R8 pattern unchanged", {devsel_n, stop_n, trdy_n}, {1'b1, es[0], et[0]});
        repeat (H - 1) @(posedge clk);
        @(negedge clk);
        check("R9 pattern held last cycle", oe, 1);
        check("R9 not yet valid", valid, 0);
        @(posedge clk);
        @(negedge clk);
        check("R9 lines released", oe, 0);
        check("R9 mode valid", valid, 1);
        check("R10 code kept", freq, ef);
        check("R10 pattern lines idle", {devsel_n, stop_n, trdy_n}, 7);
    endtask

    task automatic t_power_on(input bit im, input logic [1:0] ic, input bit ia, input int ef);
        m66 = im; cap = ic; a133 = ia; req = 1'b1; rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R12 oe after reset", oe, 0);
        check("R12 bus reset asserted", brst_n, 0);
        check("R12 valid low", valid, 0);
        check("R12 code clear", freq, 0);
        rst_n = 1'b1;
        run_body(ef, 0, 0, 0, 1'b0);
    endtask

    task automatic t_rerun(input string tag, input bit im, input logic [1:0] ic, input bit ia,
                           input int ef, input int ep, input int ee,
                           input int extra, input bit disturb);
        @(negedge clk);
        m66 = im; cap = ic; a133 = ia; req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check({"R11 valid drops ", tag}, valid, 0);
        check({"R11 bus reset reasserted ", tag}, brst_n, 0);
        run_body(ef, ep, ee, extra, disturb);
    endtask

    initial begin
        t_power_on(1'b0, 2'b00, 1'b1, 0);                          // R1 33
        t_rerun("c66", 1'b1, 2'b00, 1'b1, 1, 0, 0, 0, 1'b0);       // R1 66
        t_rerun("x66a", 1'b0, 2'b01, 1'b1, 2, 1, 0, 0, 1'b0);      // R2
        t_rerun("x66b", 1'b1, 2'b01, 1'b0, 2, 1, 0, 0, 1'b0);      // R2
        t_rerun("x100", 1'b0, 2'b10, 1'b1, 3, 1, 0, 0, 1'b0);      // R3
        t_rerun("x133", 1'b1, 2'b10, 1'b1, 4, 1, 0, 3, 1'b1);      // R3 R8 R10
        t_rerun("cap133", 1'b1, 2'b10, 1'b0, 3, 1, 0, 0, 1'b0);    // R3 limit
        t_rerun("rsvd", 1'b1, 2'b11, 1'b1, 0, 0, 1, 0, 1'b0);      // R4
        t_rerun("c33n", 1'b0, 2'b00, 1'b0, 0, 0, 0, 1, 1'b0);      // R1 strap ignored
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog R9 act=0 exp=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule